// File: doc/BRIEF.md
# Masked Multi-Lane Vector Sequencer

The sequencer executes one vector arithmetic instruction at a time over a register file that is split across `NLANE` parallel lanes. Element `i` of every vector register lives in lane `i mod NLANE`. An instruction covering `vl` elements is strip-mined: each cycle handles one group of `NLANE` consecutive elements, so the instruction takes `ceil(vl/NLANE)` cycles. In the last group, lanes whose element index is `vl` or higher are switched off.

A bank of flag registers holds one bit per element. A masked instruction writes only the elements whose selected flag bit is set. A merge picks each destination element from one of two sources, steered by its flag bit. A signed less-than compare writes its per-element result into a flag register, which allows a masked swap to follow it.

A host port loads single elements and whole flag registers while the block is idle. Read ports return any element and any flag register.

Top module: `vseq_top`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `iss_ready_o` is 1, and every vector element and every flag bit reads 0.
- R2: For each element `i < vl` that is written, the result is `va[i] op vb[i]` on `DW` bits. The opcode encodings are 0 add, 1 subtract, 2 multiply (low `DW` bits), 3 AND, 4 OR and 5 XOR.
- R3: An instruction with `vl > 0` accepted at clock edge t keeps `busy_o` high for exactly `ceil(vl/NLANE)` cycles. `busy_o` falls at the same edge where `done_o` rises for a single cycle.
- R4: An instruction with `vl = 0` never raises `busy_o`, pulses `done_o` in the cycle after acceptance, and changes no register.
- R5: Elements with index `>= vl` are never modified by an instruction, including lanes in a partial last group.
- R6: When `iss_mask_i` is 1, an element whose bit in flag register `iss_vf_i` is 0 keeps its previous destination value (opcodes 0–5 and 7).
- R7: Opcode 6 (merge) writes `vd[i] = flag[vf][i] ? va[i] : vb[i]` for every `i < vl`, whatever the value of `iss_mask_i`.
- R8: Opcode 7 (compare) writes bit `i` of flag register `vd mod NFLAG` with the signed result `va[i] < vb[i]`. It leaves every vector register unchanged, and it obeys the `vl` limit and the mask.
- R9: `iss_ready_o` equals `!busy_o`. An issue request presented while busy is ignored.
- R10: Host element writes (`hw_*`) and flag writes (`fw_*`) take effect at the next edge when idle and are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | Sequencer idle, issue accepted |
| iss_op_i | input | 3 | Opcode |
| iss_vd_i | input | $clog2(NVREG) | Destination register (flag index for compare) |
| iss_va_i | input | $clog2(NVREG) | First source register |
| iss_vb_i | input | $clog2(NVREG) | Second source register |
| iss_vf_i | input | $clog2(NFLAG) | Flag register for mask or merge |
| iss_mask_i | input | 1 | Enable flag masking |
| iss_vl_i | input | $clog2(MVL+1) | Vector length, 0..MVL |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hw_en_i | input | 1 | Host element write enable |
| hw_reg_i | input | $clog2(NVREG) | Host write register |
| hw_elem_i | input | $clog2(MVL) | Host write element index |
| hw_data_i | input | DW | Host write data |
| fw_en_i | input | 1 | Flag register write enable |
| fw_idx_i | input | $clog2(NFLAG) | Flag register index |
| fw_bits_i | input | MVL | Flag register value |
| rd_reg_i | input | $clog2(NVREG) | Read register |
| rd_elem_i | input | $clog2(MVL) | Read element index |
| rd_data_o | output | DW | Read element value |
| frd_idx_i | input | $clog2(NFLAG) | Flag read index |
| frd_bits_o | output | MVL | Flag read value |

## Verification
The assertions assume that an accepted `iss_vl_i` never exceeds `MVL` and that the parameters give `MVL` as a multiple of `NLANE`. The stimulus draws `vl` only from 0 to `MVL` and keeps the default geometry. The stimulus deliberately drives issue requests and host writes while the block is busy, because the design must reject them. Every drive takes place on the falling edge, so the assertions see settled inputs at the active edge.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_MRG = 3'd6,
    OP_CLT = 3'd7
  } vop_e;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl import vseq_pkg::*; #(
  parameter int NLANE = 4,
  parameter int MVL   = 16,
  parameter int NVREG = 8,
  parameter int NFLAG = 4,
  localparam int ROWS = MVL / NLANE,
  localparam int GW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int RW   = $clog2(NVREG),
  localparam int FW   = $clog2(NFLAG),
  localparam int LW   = $clog2(MVL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iss_valid_i,
  input  logic [2:0]       iss_op_i,
  input  logic [RW-1:0]    iss_vd_i,
  input  logic [RW-1:0]    iss_va_i,
  input  logic [RW-1:0]    iss_vb_i,
  input  logic [FW-1:0]    iss_vf_i,
  input  logic             iss_mask_i,
  input  logic [LW-1:0]    iss_vl_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [GW-1:0]    grp_o,
  output logic [NLANE-1:0] lane_en_o,
  output vop_e             op_o,
  output logic [RW-1:0]    vd_o,
  output logic [RW-1:0]    va_o,
  output logic [RW-1:0]    vb_o,
  output logic [FW-1:0]    vf_o,
  output logic             mask_o,
  output logic [LW-1:0]    vl_o
);
  logic          busy_q, done_q;
  logic [GW-1:0] grp_q, last_q;
  vop_e          op_q;
  logic [RW-1:0] vd_q, va_q, vb_q;
  logic [FW-1:0] vf_q;
  logic          mask_q;
  logic [LW-1:0] vl_q;
  logic          accept;

  assign accept = iss_valid_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      grp_q  <= '0;
      last_q <= '0;
      op_q   <= OP_ADD;
      vd_q   <= '0;
      va_q   <= '0;
      vb_q   <= '0;
      vf_q   <= '0;
      mask_q <= 1'b0;
      vl_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q   <= vop_e'(iss_op_i);
        vd_q   <= iss_vd_i;
        va_q   <= iss_va_i;
        vb_q   <= iss_vb_i;
        vf_q   <= iss_vf_i;
        mask_q <= iss_mask_i;
        vl_q   <= iss_vl_i;
        grp_q  <= '0;
        if (iss_vl_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          last_q <= GW'((int'(iss_vl_i) - 1) / NLANE);
        end
      end else if (busy_q) begin
        if (grp_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          grp_q <= grp_q + 1'b1;
        end
      end
    end
  end

  // lanes past vl are off in the tail group
  for (genvar l = 0; l < NLANE; l++) begin : g_en
    assign lane_en_o[l] = busy_q && ((int'(grp_q) * NLANE + l) < int'(vl_q));
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign grp_o  = grp_q;
  assign op_o   = op_q;
  assign vd_o   = vd_q;
  assign va_o   = va_q;
  assign vb_o   = vb_q;
  assign vf_o   = vf_q;
  assign mask_o = mask_q;
  assign vl_o   = vl_q;

  // R3
  grp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (grp_q <= last_q));
  // R3
  last_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && grp_q == last_q) |=> (done_q && !busy_q));
  // R9
  accept_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> ($past(iss_valid_i) && !$past(busy_q)));
  // R4
  zero_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && iss_vl_i == '0) |=> (done_q && !busy_q));
  // R5
  vl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (int'(iss_vl_i) <= MVL));
endmodule

// File: rtl/vseq_lane.sv
module vseq_lane import vseq_pkg::*; #(
  parameter int L     = 0,
  parameter int NLANE = 4,
  parameter int MVL   = 16,
  parameter int DW    = 16,
  parameter int NVREG = 8,
  localparam int ROWS = MVL / NLANE,
  localparam int GW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int RW   = $clog2(NVREG),
  localparam int LW   = $clog2(MVL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [GW-1:0] row_i,
  input  logic [LW-1:0] vl_i,
  input  vop_e          op_i,
  input  logic [RW-1:0] vd_i,
  input  logic [RW-1:0] va_i,
  input  logic [RW-1:0] vb_i,
  input  logic          mask_i,
  input  logic          fbit_i,
  input  logic          hw_we_i,
  input  logic [RW-1:0] hw_reg_i,
  input  logic [GW-1:0] hw_row_i,
  input  logic [DW-1:0] hw_data_i,
  input  logic [RW-1:0] rd_reg_i,
  input  logic [GW-1:0] rd_row_i,
  output logic [DW-1:0] rd_data_o,
  output logic          cmp_o
);
  logic [DW-1:0] mem_q [NVREG][ROWS];
  logic [DW-1:0] opa, opb, res;
  logic          vwe;

  assign opa = mem_q[va_i][row_i];
  assign opb = mem_q[vb_i][row_i];

  always_comb begin
    unique case (op_i)
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_MUL:  res = opa * opb;
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_MRG:  res = fbit_i ? opa : opb;
      default: res = opa;
    endcase
  end

  assign cmp_o = $signed(opa) < $signed(opb);
  assign vwe   = en_i && (op_i != OP_CLT) && ((op_i == OP_MRG) || !mask_i || fbit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NVREG; r++)
        for (int w = 0; w < ROWS; w++)
          mem_q[r][w] <= '0;
    end else if (vwe) begin
      mem_q[vd_i][row_i] <= res;
    end else if (hw_we_i) begin
      mem_q[hw_reg_i][hw_row_i] <= hw_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_reg_i][rd_row_i];

  // R5
  lane_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ((int'(row_i) * NLANE + L) < int'(vl_i)));
  // R10
  host_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_we_i |-> !en_i);
endmodule

// File: rtl/vseq_top.sv
module vseq_top import vseq_pkg::*; #(
  parameter int NLANE = 4,
  parameter int MVL   = 16,
  parameter int DW    = 16,
  parameter int NVREG = 8,
  parameter int NFLAG = 4,
  localparam int ROWS = MVL / NLANE,
  localparam int GW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int RW   = $clog2(NVREG),
  localparam int FW   = $clog2(NFLAG),
  localparam int EW   = $clog2(MVL),
  localparam int LW   = $clog2(MVL + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           iss_valid_i,
  output logic           iss_ready_o,
  input  logic [2:0]     iss_op_i,
  input  logic [RW-1:0]  iss_vd_i,
  input  logic [RW-1:0]  iss_va_i,
  input  logic [RW-1:0]  iss_vb_i,
  input  logic [FW-1:0]  iss_vf_i,
  input  logic           iss_mask_i,
  input  logic [LW-1:0]  iss_vl_i,
  output logic           busy_o,
  output logic           done_o,
  input  logic           hw_en_i,
  input  logic [RW-1:0]  hw_reg_i,
  input  logic [EW-1:0]  hw_elem_i,
  input  logic [DW-1:0]  hw_data_i,
  input  logic           fw_en_i,
  input  logic [FW-1:0]  fw_idx_i,
  input  logic [MVL-1:0] fw_bits_i,
  input  logic [RW-1:0]  rd_reg_i,
  input  logic [EW-1:0]  rd_elem_i,
  output logic [DW-1:0]  rd_data_o,
  input  logic [FW-1:0]  frd_idx_i,
  output logic [MVL-1:0] frd_bits_o
);
  logic             busy;
  logic [GW-1:0]    grp;
  logic [NLANE-1:0] lane_en, cmp, fbit;
  vop_e             op;
  logic [RW-1:0]    vd, va, vb;
  logic [FW-1:0]    vf;
  logic             mask;
  logic [LW-1:0]    vl;
  logic [MVL-1:0]   flag_q [NFLAG];
  logic [DW-1:0]    lane_rd [NLANE];
  logic [FW-1:0]    vd_f;

  vseq_ctrl #(.NLANE(NLANE), .MVL(MVL), .NVREG(NVREG), .NFLAG(NFLAG)) i_ctrl (
    .clk_i, .rst_ni, .iss_valid_i, .iss_op_i, .iss_vd_i, .iss_va_i, .iss_vb_i,
    .iss_vf_i, .iss_mask_i, .iss_vl_i,
    .busy_o(busy), .done_o, .grp_o(grp), .lane_en_o(lane_en), .op_o(op),
    .vd_o(vd), .va_o(va), .vb_o(vb), .vf_o(vf), .mask_o(mask), .vl_o(vl)
  );

  assign busy_o      = busy;
  assign iss_ready_o = !busy;
  assign vd_f        = FW'(int'(vd) % NFLAG);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [EW-1:0] elem;
    logic          hw_hit;
    assign elem    = EW'(int'(grp) * NLANE + l);
    assign fbit[l] = flag_q[vf][elem];
    assign hw_hit  = hw_en_i && !busy && ((int'(hw_elem_i) % NLANE) == l);

    vseq_lane #(.L(l), .NLANE(NLANE), .MVL(MVL), .DW(DW), .NVREG(NVREG)) i_lane (
      .clk_i, .rst_ni,
      .en_i(lane_en[l]), .row_i(grp), .vl_i(vl), .op_i(op),
      .vd_i(vd), .va_i(va), .vb_i(vb), .mask_i(mask), .fbit_i(fbit[l]),
      .hw_we_i(hw_hit), .hw_reg_i(hw_reg_i),
      .hw_row_i(GW'(int'(hw_elem_i) / NLANE)), .hw_data_i(hw_data_i),
      .rd_reg_i(rd_reg_i), .rd_row_i(GW'(int'(rd_elem_i) / NLANE)),
      .rd_data_o(lane_rd[l]), .cmp_o(cmp[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < NFLAG; f++) flag_q[f] <= '0;
    end else begin
      if (fw_en_i && !busy) flag_q[fw_idx_i] <= fw_bits_i;
      for (int l = 0; l < NLANE; l++) begin
        if (lane_en[l] && op == OP_CLT && (!mask || fbit[l]))
          flag_q[vd_f][EW'(int'(grp) * NLANE + l)] <= cmp[l];
      end
    end
  end

  assign rd_data_o  = lane_rd[int'(rd_elem_i) % NLANE];
  assign frd_bits_o = flag_q[frd_idx_i];

  // R8
  flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !fw_en_i) |=> $stable(flag_q[frd_idx_i]) || $changed(frd_idx_i));
  // R9
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_ready_o != busy_o);
  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(iss_valid_i));
endmodule

// File: tb/test_vseq_top.sv
module test_vseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NLANE = 4;
  localparam int MVL   = 16;
  localparam int DW    = 16;
  localparam int NVREG = 8;
  localparam int NFLAG = 4;
  localparam int RW = $clog2(NVREG);
  localparam int FW = $clog2(NFLAG);
  localparam int EW = $clog2(MVL);
  localparam int LW = $clog2(MVL + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic iss_valid_i = 0, iss_ready_o, iss_mask_i = 0;
  logic [2:0] iss_op_i = '0;
  logic [RW-1:0] iss_vd_i = '0, iss_va_i = '0, iss_vb_i = '0;
  logic [FW-1:0] iss_vf_i = '0;
  logic [LW-1:0] iss_vl_i = '0;
  logic busy_o, done_o;
  logic hw_en_i = 0;
  logic [RW-1:0] hw_reg_i = '0, rd_reg_i = '0;
  logic [EW-1:0] hw_elem_i = '0, rd_elem_i = '0;
  logic [DW-1:0] hw_data_i = '0, rd_data_o;
  logic fw_en_i = 0;
  logic [FW-1:0] fw_idx_i = '0, frd_idx_i = '0;
  logic [MVL-1:0] fw_bits_i = '0, frd_bits_o;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0]  ref_v [NVREG][MVL];
  logic [MVL-1:0] ref_f [NFLAG];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vseq_top #(.NLANE(NLANE), .MVL(MVL), .DW(DW), .NVREG(NVREG), .NFLAG(NFLAG)) i_vseq_top (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    bit ok = 1;
    longint a = 0, e = 0;
    for (int r = 0; r < NVREG; r++)
      for (int i = 0; i < MVL; i++) begin
        rd_reg_i = RW'(r); rd_elem_i = EW'(i); #1;
        if (ok && rd_data_o !== ref_v[r][i]) begin
          ok = 0; a = longint'(rd_data_o); e = longint'(ref_v[r][i]);
        end
      end
    for (int f = 0; f < NFLAG; f++) begin
      frd_idx_i = FW'(f); #1;
      if (ok && frd_bits_o !== ref_f[f]) begin
        ok = 0; a = longint'(frd_bits_o); e = longint'(ref_f[f]);
      end
    end
    chk(ok, req, a, e);
  endtask

  task automatic host_wr(input int r, input int i, input logic [DW-1:0] d);
    @(negedge clk_i);
    hw_en_i = 1; hw_reg_i = RW'(r); hw_elem_i = EW'(i); hw_data_i = d;
    @(negedge clk_i);
    hw_en_i = 0;
    ref_v[r][i] = d;
  endtask

  task automatic flag_wr(input int f, input logic [MVL-1:0] b);
    @(negedge clk_i);
    fw_en_i = 1; fw_idx_i = FW'(f); fw_bits_i = b;
    @(negedge clk_i);
    fw_en_i = 0;
    ref_f[f] = b;
  endtask

  function automatic void model(input int op, input int vd, input int va, input int vb,
                                input int vf, input bit m, input int vl);
    logic [DW-1:0]  nv [MVL];
    logic [MVL-1:0] nf;
    for (int i = 0; i < MVL; i++) nv[i] = ref_v[vd][i];
    nf = ref_f[vd % NFLAG];
    for (int i = 0; i < vl; i++) begin
      logic [DW-1:0] a, b;
      bit fb;
      a = ref_v[va][i]; b = ref_v[vb][i]; fb = ref_f[vf][i];
      case (op)
        0: if (!m || fb) nv[i] = a + b;
        1: if (!m || fb) nv[i] = a - b;
        2: if (!m || fb) nv[i] = DW'(a * b);
        3: if (!m || fb) nv[i] = a & b;
        4: if (!m || fb) nv[i] = a | b;
        5: if (!m || fb) nv[i] = a ^ b;
        6: nv[i] = fb ? a : b;
        default: if (!m || fb) nf[i] = $signed(a) < $signed(b);
      endcase
    end
    if (op == 7) ref_f[vd % NFLAG] = nf;
    else for (int i = 0; i < MVL; i++) ref_v[vd][i] = nv[i];
  endfunction

  task automatic run(input int op, input int vd, input int va, input int vb, input int vf,
                     input bit m, input int vl, input string req, input bit inj);
    int cnt = 0;
    int exp_cyc = (vl + NLANE - 1) / NLANE;
    @(negedge clk_i);
    iss_valid_i = 1; iss_op_i = 3'(op); iss_vd_i = RW'(vd); iss_va_i = RW'(va);
    iss_vb_i = RW'(vb); iss_vf_i = FW'(vf); iss_mask_i = m; iss_vl_i = LW'(vl);
    @(negedge clk_i);
    iss_valid_i = 0;
    while (busy_o && cnt < 100) begin
      if (cnt == 0 && inj) begin
        // R9 R10: requests while busy must be dropped
        iss_valid_i = 1; iss_op_i = 3'd0; iss_vd_i = RW'(vb); iss_vl_i = LW'(MVL);
        hw_en_i = 1; hw_reg_i = RW'(va); hw_elem_i = '0; hw_data_i = 16'hBEEF;
        fw_en_i = 1; fw_idx_i = FW'(vf); fw_bits_i = ~ref_f[vf];
        chk(iss_ready_o == 1'b0, "R9 ready low while busy", iss_ready_o, 0);
      end
      cnt++;
      @(negedge clk_i);
      iss_valid_i = 0; hw_en_i = 0; fw_en_i = 0;
    end
    chk(cnt == exp_cyc, vl == 0 ? "R4 busy cycles" : "R3 busy cycles", cnt, exp_cyc);
    chk(done_o == 1'b1, "R3 done pulse", done_o, 1);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R3 done single cycle", {done_o, busy_o}, 0);
    model(op, vd, va, vb, vf, m, vl);
    check_state(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int r = 0; r < NVREG; r++) for (int i = 0; i < MVL; i++) ref_v[r][i] = '0;
    for (int f = 0; f < NFLAG; f++) ref_f[f] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    chk(!busy_o && !done_o && iss_ready_o, "R1 reset outputs", {busy_o, done_o, iss_ready_o}, 1);
    check_state("R1 reset state");

    // R10 host loads while idle
    for (int r = 0; r < NVREG; r++)
      for (int i = 0; i < MVL; i++)
        host_wr(r, i, ($urandom % 4 == 0) ? DW'($urandom % 8) : DW'($urandom));
    for (int f = 0; f < NFLAG; f++) flag_wr(f, MVL'($urandom));
    check_state("R10 idle host writes");

    // directed corners
    run(0, 1, 2, 3, 0, 0, MVL, "R2 add full length", 0);
    run(1, 4, 1, 5, 0, 0, 5, "R5 sub tail vl=5", 0);
    run(2, 6, 6, 7, 0, 0, 0, "R4 vl=0 no change", 0);
    run(2, 2, 3, 4, 1, 1, 11, "R6 masked mul", 0);
    run(6, 0, 1, 2, 2, 0, 13, "R7 merge", 0);
    run(6, 3, 4, 5, 1, 1, 7, "R7 merge ignores mask", 0);
    run(7, 2, 5, 6, 0, 0, MVL, "R8 compare to flag", 0);
    run(7, 5, 0, 1, 3, 1, 9, "R8 masked compare tail", 0);
    // masked swap following a compare
    run(7, 3, 6, 7, 0, 0, MVL, "R8 compare for swap", 0);
    run(6, 0, 7, 6, 3, 0, MVL, "R7 swap low", 0);
    run(6, 1, 6, 7, 3, 0, MVL, "R7 swap high", 0);
    run(5, 7, 2, 3, 1, 0, 3, "R9 R10 drops while busy", 1);
    run(3, 6, 4, 0, 2, 1, 1, "R9 R10 drops single group", 1);

    for (int k = 0; k < 60; k++) begin
      int vl;
      vl = (k % 10 == 0) ? MVL : (k % 10 == 1) ? 0 : int'($urandom % (MVL + 1));
      if (k % 7 == 3) flag_wr(int'($urandom % NFLAG), MVL'($urandom));
      run(int'($urandom % 8), int'($urandom % NVREG), int'($urandom % NVREG),
          int'($urandom % NVREG), int'($urandom % NFLAG), 1'($urandom), vl,
          "R2 R5 R6 random", (k % 5 == 2));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule